// File: doc/BRIEF.md
# Priority Address Region Decoder

This block sits between a processor's load/store path and its memory subsystem. For every access it looks at the 32-bit address, the access size and the read/write flag. It reports which region the access belongs to, the offset inside that region and whether the access landed nowhere. The regions are:

- a small boot ROM;
- two tightly coupled memories (one for instructions, one for data) whose windows are set at run time;
- main RAM;
- a shared RAM window;
- an I/O page.

Each region mirrors its contents across its address range, because only the low offset bits are kept.

The checks run in a fixed order. The boot ROM is tried first, and only for reads. Next come the instruction TCM, which starts at address zero, and then the data TCM, which has a programmable base. Last comes the fixed map, which is keyed on the top address byte. The TCM windows are loaded through a small configuration write port. After reset both TCM windows are empty. The memory arrays and the I/O register contents live outside this block. A consumer returns zero for a read flagged as unmapped and drops a write flagged as unmapped.

Top module: `addr_region_decoder`

## Requirements
- R1: After reset, dec_valid, dec_unmapped, dec_region and dec_offset are all 0, the instruction TCM size is 0, the data TCM base is 0xFFFFFFFF and its size is 0. No access decodes to either TCM until the port loads them.
- R2: A read whose address bits [31:12] equal 0xFFFF0 decodes to region 1 (boot ROM) with offset addr[11:0]. This check ranks above every other region.
- R3: A write inside the boot ROM range is never decoded as boot ROM. It is decoded by the remaining rules, so it is unmapped unless a TCM window covers it.
- R4: An address below the programmed instruction TCM size decodes to region 2 with offset addr & 0x7FFF. This check ranks above the data TCM and the fixed map.
- R5: An address with base <= addr < base + size (data TCM) decodes to region 3 with offset (addr - base) & 0x3FFF. This check ranks above the fixed map.
- R6: Top byte 0x02 gives region 4 (main RAM, offset addr & 0x3FFFFF). Top byte 0x03 gives region 5 (shared window, offset addr & 0x7FFF). Top byte 0x04 gives region 6 (I/O, offset addr & 0xFFFFFF).
- R7: An access that matches no region gives region 0, offset 0 and dec_unmapped = 1.
- R8: acc_size 0 is a byte and leaves the offset unchanged. Size 1 is a halfword and clears offset bit 0. Sizes 2 and 3 are a word and clear offset bits 1:0.
- R9: cfg_sel 0 loads the instruction TCM size, 1 loads the data TCM base and 2 loads the data TCM size. Selector 3 changes nothing. A load affects accesses presented in later cycles. An access presented in the same cycle as the load uses the old values.
- R10: The result appears one clock after acc_valid. dec_write echoes the access's write flag. dec_valid is 0 after a cycle without acc_valid.
- R11: The window end base + size is computed with 33 bits. A data TCM window that reaches the top of the address space covers its last byte and never wraps around to low addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_sel | input | 2 | Configuration target: 0 ITCM size, 1 DTCM base, 2 DTCM size, 3 none |
| cfg_wdata | input | 32 | Configuration value |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access byte address |
| acc_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| acc_write | input | 1 | 1 for write, 0 for read |
| dec_valid | output | 1 | Decoded result valid |
| dec_region | output | 3 | Region code 0..6 |
| dec_offset | output | 32 | Masked, aligned offset inside the region |
| dec_unmapped | output | 1 | Access matched no region |
| dec_write | output | 1 | Write flag of the decoded access |

## Verification
The bench targets four corner cases:

- Overlap ordering. The data TCM is placed on top of main RAM and then over the boot ROM range. A wrong priority would report main RAM or boot ROM where the TCM should win, or would let a boot-range write hit the ROM.
- Window edges. Accesses hit the exact base, base + size - 1 and base + size. A window that reaches 0xFFFFFFFF is also tested, where 32-bit end arithmetic would wrap and either miss the last bytes or claim low addresses.
- Load timing. A load is issued in the same cycle as an access. A design that forwarded the new value early, or applied it late, would decode the wrong region.
- Alignment. The masks are checked under all three access sizes.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

   localparam int ADDR_W = 32;

   typedef enum logic [2:0] {
      RG_NONE   = 3'd0,
      RG_BOOT   = 3'd1,
      RG_ITCM   = 3'd2,
      RG_DTCM   = 3'd3,
      RG_MAIN   = 3'd4,
      RG_SHARED = 3'd5,
      RG_IO     = 3'd6
   } region_e;

   typedef enum logic [1:0] {
      CF_ITCM_SIZE = 2'd0,
      CF_DTCM_BASE = 2'd1,
      CF_DTCM_SIZE = 2'd2,
      CF_NONE      = 2'd3
   } cfg_sel_e;

   function automatic logic [ADDR_W-1:0] low_mask(input int w);
      return (w >= ADDR_W) ? '1 : ((ADDR_W'(1) << w) - ADDR_W'(1));
   endfunction

endpackage

// File: rtl/addr_dec_cfg.sv
module addr_dec_cfg
   import addr_dec_pkg::*;
#(
   parameter logic [ADDR_W-1:0] ITCM_SIZE_RST = '0,
   parameter logic [ADDR_W-1:0] DTCM_BASE_RST = '1,
   parameter logic [ADDR_W-1:0] DTCM_SIZE_RST = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_sel,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] itcm_size,
   output logic [ADDR_W-1:0] dtcm_base,
   output logic [ADDR_W-1:0] dtcm_size
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         itcm_size <= ITCM_SIZE_RST;
         dtcm_base <= DTCM_BASE_RST;
         dtcm_size <= DTCM_SIZE_RST;
      end else if (cfg_we) begin
         unique case (cfg_sel_e'(cfg_sel))
            CF_ITCM_SIZE: itcm_size <= cfg_wdata;
            CF_DTCM_BASE: dtcm_base <= cfg_wdata;
            CF_DTCM_SIZE: dtcm_size <= cfg_wdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/addr_dec_tcm_win.sv
module addr_dec_tcm_win
   import addr_dec_pkg::*;
#(
   parameter int MASK_W = 14
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] size,
   output logic              hit,
   output logic [ADDR_W-1:0] offset
);

   localparam logic [ADDR_W-1:0] MASK = low_mask(MASK_W);

   generate
      if (MASK_W < 1 || MASK_W > ADDR_W) begin : g_bad_mask
         $error("addr_dec_tcm_win: MASK_W out of range");
      end
   endgenerate

   logic [ADDR_W:0] win_end;
   logic [ADDR_W:0] addr_ext;

   always_comb begin
      win_end  = {1'b0, base} + {1'b0, size};
      addr_ext = {1'b0, addr};
      hit      = (addr >= base) && (addr_ext < win_end);
      offset   = (addr - base) & MASK;
   end

endmodule

// File: rtl/addr_dec_fixed_map.sv
module addr_dec_fixed_map
   import addr_dec_pkg::*;
#(
   parameter int         MAIN_W     = 22,
   parameter int         SHARED_W   = 15,
   parameter int         IO_W       = 24,
   parameter logic [7:0] MAIN_TAG   = 8'h02,
   parameter logic [7:0] SHARED_TAG = 8'h03,
   parameter logic [7:0] IO_TAG     = 8'h04
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output region_e           region,
   output logic [ADDR_W-1:0] offset
);

   localparam int N_REG  = 3;
   localparam int TAG_LO = ADDR_W - 8;

   generate
      if (MAIN_TAG == SHARED_TAG || MAIN_TAG == IO_TAG || SHARED_TAG == IO_TAG) begin : g_dup_tag
         $error("addr_dec_fixed_map: region tags must differ");
      end
      if (MAIN_W > TAG_LO || SHARED_W > TAG_LO || IO_W > TAG_LO) begin : g_wide_mask
         $error("addr_dec_fixed_map: mask wider than the page below the tag byte");
      end
   endgenerate

   logic [N_REG-1:0]        sub_hit;
   logic [ADDR_W-1:0]       sub_off  [N_REG];
   logic [2:0]              sub_code [N_REG];

   for (genvar g = 0; g < N_REG; g++) begin : g_page
      localparam int          W    = (g == 0) ? MAIN_W   : (g == 1) ? SHARED_W   : IO_W;
      localparam logic [7:0]  TAG  = (g == 0) ? MAIN_TAG : (g == 1) ? SHARED_TAG : IO_TAG;
      localparam logic [2:0]  CODE = (g == 0) ? RG_MAIN  : (g == 1) ? RG_SHARED  : RG_IO;
      localparam logic [ADDR_W-1:0] M = low_mask(W);
      assign sub_hit[g]  = (addr[ADDR_W-1:TAG_LO] == TAG);
      assign sub_off[g]  = sub_hit[g] ? (addr & M) : '0;
      assign sub_code[g] = sub_hit[g] ? CODE : 3'd0;
   end

   always_comb begin
      logic [ADDR_W-1:0] off_acc;
      logic [2:0]        code_acc;
      off_acc  = '0;
      code_acc = '0;
      for (int i = 0; i < N_REG; i++) begin
         off_acc  = off_acc  | sub_off[i];
         code_acc = code_acc | sub_code[i];
      end
      hit    = |sub_hit;
      region = region_e'(code_acc);
      offset = off_acc;
   end

endmodule

// File: rtl/addr_region_decoder.sv
module addr_region_decoder
   import addr_dec_pkg::*;
#(
   parameter int          BOOT_W     = 12,
   parameter logic [19:0] BOOT_TAG   = 20'hFFFF0,
   parameter int          ITCM_W     = 15,
   parameter int          DTCM_W     = 14,
   parameter int          MAIN_W     = 22,
   parameter int          SHARED_W   = 15,
   parameter int          IO_W       = 24,
   parameter logic [7:0]  MAIN_TAG   = 8'h02,
   parameter logic [7:0]  SHARED_TAG = 8'h03,
   parameter logic [7:0]  IO_TAG     = 8'h04
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cfg_we,
   input  logic [1:0]  cfg_sel,
   input  logic [31:0] cfg_wdata,
   input  logic        acc_valid,
   input  logic [31:0] acc_addr,
   input  logic [1:0]  acc_size,
   input  logic        acc_write,
   output logic        dec_valid,
   output logic [2:0]  dec_region,
   output logic [31:0] dec_offset,
   output logic        dec_unmapped,
   output logic        dec_write
);

   localparam int                BOOT_TAG_W = ADDR_W - BOOT_W;
   localparam logic [ADDR_W-1:0] BOOT_MASK  = low_mask(BOOT_W);

   generate
      if (BOOT_TAG_W != 20) begin : g_boot_geom
         $error("addr_region_decoder: BOOT_W must leave a 20-bit tag");
      end
   endgenerate

   logic [ADDR_W-1:0] itcm_size, dtcm_base, dtcm_size;

   addr_dec_cfg u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_we    (cfg_we),
      .cfg_sel   (cfg_sel),
      .cfg_wdata (cfg_wdata),
      .itcm_size (itcm_size),
      .dtcm_base (dtcm_base),
      .dtcm_size (dtcm_size)
   );

   logic              itcm_hit, dtcm_hit, map_hit;
   logic [ADDR_W-1:0] itcm_off, dtcm_off, map_off;
   region_e           map_region;

   addr_dec_tcm_win #(.MASK_W(ITCM_W)) u_itcm (
      .addr   (acc_addr),
      .base   ('0),
      .size   (itcm_size),
      .hit    (itcm_hit),
      .offset (itcm_off)
   );

   addr_dec_tcm_win #(.MASK_W(DTCM_W)) u_dtcm (
      .addr   (acc_addr),
      .base   (dtcm_base),
      .size   (dtcm_size),
      .hit    (dtcm_hit),
      .offset (dtcm_off)
   );

   addr_dec_fixed_map #(
      .MAIN_W     (MAIN_W),
      .SHARED_W   (SHARED_W),
      .IO_W       (IO_W),
      .MAIN_TAG   (MAIN_TAG),
      .SHARED_TAG (SHARED_TAG),
      .IO_TAG     (IO_TAG)
   ) u_map (
      .addr   (acc_addr),
      .hit    (map_hit),
      .region (map_region),
      .offset (map_off)
   );

   logic              boot_hit;
   region_e           sel_region;
   logic [ADDR_W-1:0] sel_off;
   logic [ADDR_W-1:0] align_mask;

   always_comb begin
      boot_hit = !acc_write && (acc_addr[ADDR_W-1:BOOT_W] == BOOT_TAG);
      if (boot_hit) begin
         sel_region = RG_BOOT;
         sel_off    = acc_addr & BOOT_MASK;
      end else if (itcm_hit) begin
         sel_region = RG_ITCM;
         sel_off    = itcm_off;
      end else if (dtcm_hit) begin
         sel_region = RG_DTCM;
         sel_off    = dtcm_off;
      end else if (map_hit) begin
         sel_region = map_region;
         sel_off    = map_off;
      end else begin
         sel_region = RG_NONE;
         sel_off    = '0;
      end
      unique case (acc_size)
         2'd0:    align_mask = '1;
         2'd1:    align_mask = ~ADDR_W'(1);
         default: align_mask = ~ADDR_W'(3);
      endcase
   end

   region_e r_region;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid    <= 1'b0;
         r_region     <= RG_NONE;
         dec_offset   <= '0;
         dec_unmapped <= 1'b0;
         dec_write    <= 1'b0;
      end else begin
         dec_valid <= acc_valid;
         if (acc_valid) begin
            r_region     <= sel_region;
            dec_offset   <= sel_off & align_mask;
            dec_unmapped <= (sel_region == RG_NONE);
            dec_write    <= acc_write;
         end
      end
   end

   assign dec_region = r_region;

endmodule

// File: rtl/addr_region_decoder_chk.sv
module addr_region_decoder_chk
   import addr_dec_pkg::*;
#(
   parameter int MAIN_W = 22
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cfg_we,
   input logic [1:0]  cfg_sel,
   input logic [31:0] cfg_wdata,
   input logic        acc_valid,
   input logic [1:0]  acc_size,
   input logic        dec_valid,
   input logic [2:0]  dec_region,
   input logic [31:0] dec_offset,
   input logic        dec_unmapped,
   input logic        dec_write
);

   logic itcm_armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) itcm_armed <= 1'b0;
      else if (cfg_we && cfg_sel == 2'd0 && cfg_wdata != 32'd0) itcm_armed <= 1'b1;
   end

   // R10: result follows the request by one cycle
   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> dec_valid);
   p_idle_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> !dec_valid);
   // R7: an unmapped result carries no region and no offset
   p_unmapped_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dec_unmapped |-> (dec_region == 3'd0 && dec_offset == 32'd0));
   // R3: a write is never reported as boot ROM
   p_boot_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_region == 3'(RG_BOOT)) |-> !dec_write);
   // R8: word accesses come out word aligned
   p_word_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && $past(acc_size) >= 2'd2) |-> (dec_offset[1:0] == 2'b00));
   // R1: no instruction TCM hit before a nonzero size has been loaded
   p_itcm_needs_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_region == 3'(RG_ITCM)) |-> itcm_armed);
   // R6: main RAM offset stays inside its mask
   p_main_in_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_region == 3'(RG_MAIN)) |-> (dec_offset < (32'd1 << MAIN_W)));

endmodule

bind addr_region_decoder addr_region_decoder_chk #(.MAIN_W(MAIN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_sel      (cfg_sel),
   .cfg_wdata    (cfg_wdata),
   .acc_valid    (acc_valid),
   .acc_size     (acc_size),
   .dec_valid    (dec_valid),
   .dec_region   (dec_region),
   .dec_offset   (dec_offset),
   .dec_unmapped (dec_unmapped),
   .dec_write    (dec_write)
);

// File: tb/addr_region_decoder_bench.sv
`timescale 1ns/1ps
module addr_region_decoder_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [31:0] cfg_wdata = '0;
   logic        acc_valid = 1'b0;
   logic [31:0] acc_addr = '0;
   logic [1:0]  acc_size = '0;
   logic        acc_write = 1'b0;
   logic        dec_valid;
   logic [2:0]  dec_region;
   logic [31:0] dec_offset;
   logic        dec_unmapped;
   logic        dec_write;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [31:0] m_isize = 32'd0;
   logic [31:0] m_dbase = 32'hFFFF_FFFF;
   logic [31:0] m_dsize = 32'd0;

   always #4 clk = ~clk;

   addr_region_decoder u_addr_region_decoder (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size), .acc_write(acc_write),
      .dec_valid(dec_valid), .dec_region(dec_region), .dec_offset(dec_offset),
      .dec_unmapped(dec_unmapped), .dec_write(dec_write)
   );

   function automatic void model(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                                 output logic [2:0] rg, output logic [31:0] off);
      logic [32:0] dend;
      dend = {1'b0, m_dbase} + {1'b0, m_dsize};
      if (!wr && a[31:12] == 20'hFFFF0) begin rg = 3'd1; off = a & 32'hFFF; end
      else if (a < m_isize) begin rg = 3'd2; off = a & 32'h7FFF; end
      else if (a >= m_dbase && {1'b0, a} < dend) begin rg = 3'd3; off = (a - m_dbase) & 32'h3FFF; end
      else begin
         case (a[31:24])
            8'h02:   begin rg = 3'd4; off = a & 32'h3F_FFFF; end
            8'h03:   begin rg = 3'd5; off = a & 32'h7FFF; end
            8'h04:   begin rg = 3'd6; off = a & 32'hFF_FFFF; end
            default: begin rg = 3'd0; off = 32'd0; end
         endcase
      end
      if (sz == 2'd1) off[0] = 1'b0;
      else if (sz >= 2'd2) off[1:0] = 2'b00;
   endfunction

   task automatic check(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic wr);
      logic [2:0]  erg;
      logic [31:0] eoff;
      model(a, sz, wr, erg, eoff);
      n_vec++;
      if (dec_valid !== 1'b1 || dec_region !== erg || dec_offset !== eoff ||
          dec_unmapped !== (erg == 3'd0) || dec_write !== wr) begin
         n_bad++;
         $display("FAIL %s addr=%h sz=%0d wr=%0b: got v=%0b rg=%0d off=%h um=%0b w=%0b exp v=1 rg=%0d off=%h um=%0b w=%0b",
                  tag, a, sz, wr, dec_valid, dec_region, dec_offset, dec_unmapped, dec_write,
                  erg, eoff, (erg == 3'd0), wr);
      end
   endtask

   task automatic access(input string tag, input logic [31:0] a, input logic [1:0] sz, input logic wr);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr;
      @(negedge clk);
      acc_valid = 1'b0;
      check(tag, a, sz, wr);
   endtask

   task automatic load(input logic [1:0] sel, input logic [31:0] val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         2'd0: m_isize = val;
         2'd1: m_dbase = val;
         2'd2: m_dsize = val;
         default: ;
      endcase
   endtask

   function automatic logic [31:0] pick_addr();
      logic [31:0] r;
      r = $urandom;
      case ($urandom % 8)
         0: return {20'hFFFF0, r[11:0]};
         1: return {16'h0000, r[15:0]};
         2: return m_dbase + (r & 32'h7FFF) - 32'h2000;
         3: return {8'h02, r[23:0]};
         4: return {8'h03, r[23:0]};
         5: return {8'h04, r[23:0]};
         6: return {8'hFF, r[23:0]};
         default: return r;
      endcase
   endfunction

   task automatic random_batch(input string tag, input int n);
      for (int i = 0; i < n; i++) begin
         logic [31:0] a;
         logic [1:0]  s;
         logic        w;
         a = pick_addr();
         s = 2'($urandom % 4);
         w = 1'($urandom % 2);
         access(tag, a, s, w);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1: idle outputs after reset
      n_vec++;
      if (dec_valid !== 1'b0 || dec_unmapped !== 1'b0 || dec_region !== 3'd0 || dec_offset !== 32'd0) begin
         n_bad++;
         $display("FAIL R1 reset: got v=%0b um=%0b rg=%0d off=%h exp all zero",
                  dec_valid, dec_unmapped, dec_region, dec_offset);
      end
      rst_n = 1'b1;
      // R1: TCMs disabled
      access("R1", 32'h0000_0010, 2'd2, 1'b0);
      access("R1", 32'hFFFF_FFFF, 2'd0, 1'b0);
      // R2 / R3: boot ROM read and write
      access("R2", 32'hFFFF_0ABC, 2'd0, 1'b0);
      access("R3", 32'hFFFF_0ABC, 2'd0, 1'b1);
      // R6: fixed map pages and mirroring
      access("R6", 32'h0212_3457, 2'd0, 1'b0);
      access("R6", 32'h03AB_CDEF, 2'd1, 1'b1);
      access("R6", 32'h04FF_FFFF, 2'd0, 1'b0);
      // R7: unmapped page
      access("R7", 32'h0500_0000, 2'd0, 1'b1);
      // R10: idle cycle drops valid
      @(negedge clk);
      n_vec++;
      if (dec_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 idle: got v=%0b exp v=0", dec_valid);
      end
      // R9: same-cycle load uses old size, next access sees new size
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 32'h0000_8000;
      acc_valid = 1'b1; acc_addr = 32'h0000_0012; acc_size = 2'd0; acc_write = 1'b0;
      @(negedge clk);
      cfg_we = 1'b0; acc_valid = 1'b0;
      check("R9", 32'h0000_0012, 2'd0, 1'b0);
      m_isize = 32'h0000_8000;
      access("R9", 32'h0000_0012, 2'd0, 1'b0);
      // R9: selector 3 changes nothing
      load(2'd3, 32'h0000_0000);
      access("R9", 32'h0000_7FFF, 2'd0, 1'b0);
      // R4: ITCM edges and alignment R8
      access("R4", 32'h0000_7FFF, 2'd1, 1'b1);
      access("R4", 32'h0000_8000, 2'd2, 1'b0);
      access("R8", 32'h0000_1237, 2'd3, 1'b0);
      // R5: DTCM over main RAM
      load(2'd1, 32'h027C_0000);
      load(2'd2, 32'h0000_4000);
      access("R5", 32'h027C_0000, 2'd0, 1'b0);
      access("R5", 32'h027C_3FFF, 2'd0, 1'b1);
      access("R5", 32'h027C_4000, 2'd0, 1'b0);
      access("R5", 32'h027B_FFFF, 2'd0, 1'b0);
      random_batch("R5", 300);
      // R11: window at the top of the address space
      load(2'd1, 32'hFFFF_C000);
      access("R11", 32'hFFFF_FFFF, 2'd0, 1'b0);
      access("R11", 32'hFFFF_C000, 2'd2, 1'b1);
      access("R11", 32'h0000_8000, 2'd0, 1'b0);
      // R3: DTCM covering boot range: reads hit ROM, writes hit DTCM
      load(2'd1, 32'hFFFF_0000);
      load(2'd2, 32'h0001_0000);
      access("R3", 32'hFFFF_0100, 2'd2, 1'b0);
      access("R3", 32'hFFFF_0100, 2'd2, 1'b1);
      random_batch("R2", 300);
      // R4: ITCM dominates a DTCM placed at zero
      load(2'd1, 32'h0000_0000);
      access("R4", 32'h0000_0100, 2'd0, 1'b1);
      access("R5", 32'h0000_8004, 2'd0, 1'b0);
      load(2'd0, 32'h0000_0000);
      random_batch("R6", 300);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule